// File: doc/BRIEF.md
# DAC Sample Format and Offset Datapath

This block prepares sample words for a pair of current-steering DAC cores, one for the I channel and one for the Q channel. Each channel takes a 16-bit sample in one of two formats and turns it into an unsigned code. Samples can arrive either as offset binary or as two's complement, and one shared control bit chooses which.

The block then adds a digital offset to the unsigned code. The offset is a 10-bit magnitude scaled by four, with a polarity bit. The polarity selects the output leg that receives the offset. When the offset goes to the positive leg, it is added to the code. When it goes to the negative leg, it is subtracted. The result saturates to the 16-bit range instead of wrapping.

A small write-only configuration port holds the format bit and each channel's own offset magnitude and polarity. The datapath has a single register stage, and a valid flag moves through the block alongside the codes.

Top module: `dacprep_top`

## Requirements
- R1: The format bit is at configuration address 0, bit 0, and resets to 0 (offset binary). In offset binary mode with a zero offset magnitude, the output code equals the input sample.
- R2: When the format bit is 1 (two's complement), the sample's MSB is inverted before the offset stage. So 0x8000 becomes 0x0000, 0x7FFF becomes 0xFFFF and 0x0000 becomes 0x8000.
- R3: The I offset magnitude is written at address 1 (magnitude bits 7:0) and address 2 (bits 1:0 give magnitude bits 9:8). Bit 7 of address 2 is the I polarity. The Q channel uses addresses 3 and 4 in the same layout. When the polarity is 1 (positive leg), the output is the unsigned code plus four times the magnitude.
- R4: When the polarity is 0 (negative leg), the output is the unsigned code minus four times the magnitude.
- R5: A sum above 0xFFFF saturates to 0xFFFF.
- R6: A difference below zero saturates to 0x0000.
- R7: Output codes and out_valid appear one clock after the inputs are sampled, and out_valid equals the in_valid of the previous cycle.
- R8: A synchronous reset clears out_valid, both output codes, both offset magnitudes, both polarity bits and the format bit.
- R9: The I and Q channels use their own offset magnitude and polarity, with no effect on each other.
- R10: A write to addresses 5 to 7 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Input samples are valid |
| in_i | input | 16 | I channel sample |
| in_q | input | 16 | Q channel sample |
| out_valid | output | 1 | Output codes are valid |
| out_i | output | 16 | I channel DAC code |
| out_q | output | 16 | Q channel DAC code |

## Verification
Each sample applied before a rising edge shows up, converted and offset, on out_i, out_q and out_valid just after that edge. The bench therefore drives on the falling edge and checks shortly after the next rising edge. A configuration write takes effect at its own edge, so it applies to the first sample accepted after the write. The bench updates its model of the settings at that same edge, and its expected values always use the settings in force when the sample is captured.

// File: rtl/dacprep_pkg.sv
package dacprep_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int MAG_W     = 10;
  localparam int OFF_SHIFT = 2;
  localparam int NUM_CH    = 2;
  localparam int CFG_AW    = 3;
  localparam int CFG_DW    = 8;
  localparam int ADDR_FMT  = 0;
endpackage

// File: rtl/dacprep_fmt.sv
module dacprep_fmt #(
  parameter int W = dacprep_pkg::SAMPLE_W
) (
  input  logic         twos,
  input  logic [W-1:0] raw,
  output logic [W-1:0] code
);
  // two's complement to offset binary: invert the sign bit
  always_comb begin
    code = raw;
    code[W-1] = raw[W-1] ^ twos;
  end
endmodule

// File: rtl/dacprep_cfg.sv
module dacprep_cfg #(
  parameter int NCH   = dacprep_pkg::NUM_CH,
  parameter int MAG_W = dacprep_pkg::MAG_W,
  parameter int AW    = dacprep_pkg::CFG_AW,
  parameter int DW    = dacprep_pkg::CFG_DW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic                      fmt_twos,
  output logic [NCH-1:0][MAG_W-1:0] mag,
  output logic [NCH-1:0]            pol
);
  localparam int HI_W = MAG_W - DW;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) fmt_twos <= 1'b0;
    else if (we && addr == AW'(dacprep_pkg::ADDR_FMT)) fmt_twos <= wdata[0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int LO_ADDR = 1 + 2 * ch;
    localparam int HI_ADDR = 2 + 2 * ch;
    always_ff @(posedge clk) begin
      if (rst) begin
        mag[ch] <= '0;
        pol[ch] <= 1'b0;
      end else if (we && addr == AW'(LO_ADDR)) begin
        mag[ch] <= {mag[ch][MAG_W-1:DW], wdata};
      end else if (we && addr == AW'(HI_ADDR)) begin
        mag[ch] <= {wdata[HI_W-1:0], mag[ch][DW-1:0]};
        pol[ch] <= wdata[DW-1];
      end
    end
    // R8: reset leaves offset cleared
    p_rst_clear_r8: assert property (@(posedge clk) rst |=> (mag[ch] == '0 && !pol[ch]));
  end
endmodule

// File: rtl/dacprep_chan.sv
module dacprep_chan #(
  parameter int W     = dacprep_pkg::SAMPLE_W,
  parameter int MAG_W = dacprep_pkg::MAG_W,
  parameter int SHIFT = dacprep_pkg::OFF_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fmt_twos,
  input  logic [W-1:0]     raw,
  input  logic [MAG_W-1:0] mag,
  input  logic             pol,
  output logic [W-1:0]     code_q
);
  localparam int EXT = W + 1;

  logic [W-1:0]   ucode;
  logic [EXT-1:0] ext, off, sum, dif;
  logic [W-1:0]   nxt;

  dacprep_fmt #(.W(W)) u_fmt (
    .twos (fmt_twos),
    .raw  (raw),
    .code (ucode)
  );

  assign ext = {1'b0, ucode};
  assign off = EXT'({mag, {SHIFT{1'b0}}});
  assign sum = ext + off;
  assign dif = ext - off;

  always_comb begin
    if (pol) nxt = sum[W] ? '1 : sum[W-1:0];
    else     nxt = dif[W] ? '0 : dif[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= nxt;
  end

  // R3: adding toward the positive leg never lowers the code
  p_add_nodec_r3: assert property (@(posedge clk) disable iff (rst)
    pol |=> code_q >= $past(ucode));
  // R4: subtracting toward the negative leg never raises the code
  p_sub_noinc_r4: assert property (@(posedge clk) disable iff (rst)
    !pol |=> code_q <= $past(ucode));
  // R1: zero magnitude passes the unsigned code through
  p_zero_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (mag == '0) |=> code_q == $past(ucode));
endmodule

// File: rtl/dacprep_top.sv
module dacprep_top #(
  parameter int W     = dacprep_pkg::SAMPLE_W,
  parameter int MAG_W = dacprep_pkg::MAG_W,
  parameter int SHIFT = dacprep_pkg::OFF_SHIFT,
  parameter int AW    = dacprep_pkg::CFG_AW,
  parameter int DW    = dacprep_pkg::CFG_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          in_valid,
  input  logic [W-1:0]  in_i,
  input  logic [W-1:0]  in_q,
  output logic          out_valid,
  output logic [W-1:0]  out_i,
  output logic [W-1:0]  out_q
);
  localparam int NCH = 2;

  logic                      fmt_twos;
  logic [NCH-1:0][MAG_W-1:0] mag;
  logic [NCH-1:0]            pol;
  logic [NCH-1:0][W-1:0]     raw, code;

  assign raw[0] = in_i;
  assign raw[1] = in_q;
  assign out_i  = code[0];
  assign out_q  = code[1];

  dacprep_cfg #(.NCH(NCH), .MAG_W(MAG_W), .AW(AW), .DW(DW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .fmt_twos (fmt_twos),
    .mag      (mag),
    .pol      (pol)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dacprep_chan #(.W(W), .MAG_W(MAG_W), .SHIFT(SHIFT)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .fmt_twos (fmt_twos),
      .raw      (raw[ch]),
      .mag      (mag[ch]),
      .pol      (pol[ch]),
      .code_q   (code[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  p_vld_on_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_vld_off_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

// File: tb/dacprep_top_bench.sv
`timescale 1ns/1ps
module dacprep_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic       m_fmt;
  logic [9:0] m_mag [2];
  logic       m_pol [2];

  always #2.5 clk = ~clk;

  dacprep_top u_dacprep_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic int model(logic [15:0] raw, logic f, logic [9:0] m, logic p);
    int u, r;
    u = f ? int'(raw ^ 16'h8000) : int'(raw);
    r = p ? u + 4 * int'(m) : u - 4 * int'(m);
    if (r > 65535) r = 65535;
    if (r < 0) r = 0;
    return r;
  endfunction

  function automatic string tag_of(logic [15:0] raw, logic f, logic [9:0] m, logic p);
    int u, r;
    u = f ? int'(raw ^ 16'h8000) : int'(raw);
    r = p ? u + 4 * int'(m) : u - 4 * int'(m);
    if (r > 65535) return "R5";
    if (r < 0) return "R6";
    if (m != 0) return p ? "R3" : "R4";
    return f ? "R2" : "R1";
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; in_valid = 1'b0;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    case (a)
      3'd0: m_fmt = d[0];
      3'd1: m_mag[0][7:0] = d;
      3'd2: begin m_mag[0][9:8] = d[1:0]; m_pol[0] = d[7]; end
      3'd3: m_mag[1][7:0] = d;
      3'd4: begin m_mag[1][9:8] = d[1:0]; m_pol[1] = d[7]; end
      default: ;
    endcase
  endtask

  // drive one sample pair, check one cycle later (R7)
  task automatic step(logic v, logic [15:0] di, logic [15:0] dq, string force_tag);
    int ei, eq;
    string ti, tq;
    @(negedge clk);
    in_valid = v; in_i = di; in_q = dq;
    ei = model(di, m_fmt, m_mag[0], m_pol[0]);
    eq = model(dq, m_fmt, m_mag[1], m_pol[1]);
    ti = (force_tag != "") ? force_tag : tag_of(di, m_fmt, m_mag[0], m_pol[0]);
    tq = (force_tag != "") ? force_tag : tag_of(dq, m_fmt, m_mag[1], m_pol[1]);
    @(posedge clk);
    #1;
    check(ti, int'(out_i), ei, "out_i");
    check(tq, int'(out_q), eq, "out_q");
    check("R7", int'(out_valid), int'(v), "out_valid");
  endtask

  initial begin
    m_fmt = 1'b0;
    m_mag[0] = '0; m_mag[1] = '0;
    m_pol[0] = 1'b0; m_pol[1] = 1'b0;
    rst = 1'b1;
    in_valid = 1'b1; in_i = 16'hFFFF; in_q = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state at the ports
    check("R8", int'(out_valid), 0, "out_valid in reset");
    check("R8", int'(out_i), 0, "out_i in reset");
    check("R8", int'(out_q), 0, "out_q in reset");
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;

    // R8/R1: defaults give offset binary pass-through
    step(1'b1, 16'h1234, 16'hFEDC, "R8");
    step(1'b1, 16'h0000, 16'h7FFF, "R1");
    step(1'b1, 16'hFFFF, 16'h8001, "R1");

    // R2: two's complement
    wr(3'd0, 8'h01);
    step(1'b1, 16'h8000, 16'h7FFF, "R2");
    step(1'b1, 16'h0000, 16'hFFFF, "R2");

    // R3/R5 on I, R4/R6 on Q; R9 independence
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h83);
    step(1'b1, 16'h1000, 16'h1000, "R9");
    step(1'b1, 16'h1000, 16'h2000, "R3");
    step(1'b1, 16'hF010, 16'h0000, "R5");
    step(1'b1, 16'hFFFF, 16'hFFFF, "R5");
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'h03);
    step(1'b1, 16'h2000, 16'h2000, "R4");
    step(1'b1, 16'h0000, 16'h0FFB, "R6");
    step(1'b1, 16'h0000, 16'h0FFC, "R4");

    // R10: unmapped addresses change nothing
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    step(1'b1, 16'h4000, 16'h4000, "R10");
    step(1'b0, 16'h8000, 16'h8000, "R10");

    // R7: valid pattern
    step(1'b0, 16'h1111, 16'h2222, "");
    step(1'b1, 16'h3333, 16'h4444, "");
    step(1'b0, 16'h5555, 16'h6666, "");

    // constrained random
    void'($urandom(32'd20240611));
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a, b;
      if ($urandom_range(0, 9) == 0)
        wr(3'($urandom_range(0, 7)), 8'($urandom));
      a = 16'($urandom);
      b = 16'($urandom);
      if ($urandom_range(0, 7) == 0) a = ($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'h0000;
      if ($urandom_range(0, 7) == 0) b = ($urandom_range(0, 1) != 0) ? 16'h8000 : 16'h7FFF;
      step(1'($urandom_range(0, 1)), a, b, "");
    end

    // R8: reset mid-run restores defaults
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R8", int'(out_valid), 0, "out_valid after reset");
    @(negedge clk);
    rst = 1'b0;
    m_fmt = 1'b0; m_mag[0] = '0; m_mag[1] = '0; m_pol[0] = 1'b0; m_pol[1] = 1'b0;
    step(1'b1, 16'hABCD, 16'h0123, "R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule